// File: doc/BRIEF.md
# Floating-Point Context Status Tracker

This block keeps the two-bit floating-point context-state field of a 32-bit machine status register. It also produces the read-only summary dirty bit that sits in the top bit of that register. Software reaches the field through status-register accesses of three kinds: a full write, a bit-set and a bit-clear. Each access carries a 32-bit operand.

The execution pipeline raises a one-cycle pulse whenever a retiring instruction writes a floating-point register. That pulse forces the field to Dirty, so an operating system can tell which tasks need their floating-point registers saved.

An enable input reports whether the floating-point extension is present. While it is low, the field is pinned to Off. The read value is combinational from the stored field. Only the field and the summary bit can be non-zero in it.

Top module: `fpctx_status`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, `csr_rdata` reads 0x00000000 (field = Off).
- R2: Field encoding in bits 14:13 is 00 Off, 01 Initial, 10 Clean, 11 Dirty. With `csr_op` = 01 (write), the field takes operand bits 14:13 at the next clock edge. For example, writing 0x00002000 reads back 0x00002000.
- R3: With `csr_op` = 10 (set), operand bits 14:13 are ORed into the field.
- R4: With `csr_op` = 11 (clear), the field is ANDed with the inverse of operand bits 14:13. Setting 0x4000 and then clearing 0x80002000 on a Dirty field reads back 0x00004000.
- R5: A `fpr_write` pulse sets the field to 11 at the next clock edge. `csr_rdata` then reads 0x80006000.
- R6: Bit 31 of `csr_rdata` is 1 exactly when the field is 11. Operand bit 31 of any access has no effect.
- R7: When a status access and a `fpr_write` pulse fall in the same cycle, the field ends at 11.
- R8: While `fp_present` is low, the field is held at 00. Both `fpr_write` and status accesses are ignored.
- R9: An access whose `csr_addr` differs from `STATUS_ADDR` (default 0x300) leaves the field unchanged.
- R10: All `csr_rdata` bits other than 31 and 14:13 read 0, whatever operand was written.
- R11: An access with `csr_valid` low or with `csr_op` = 00 leaves the field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_present | input | 1 | Floating-point extension present |
| csr_valid | input | 1 | Status-register access strobe |
| csr_addr | input | ADDR_W | Register address of the access |
| csr_op | input | 2 | 00 none, 01 write, 10 set, 11 clear |
| csr_wdata | input | 32 | Access operand |
| fpr_write | input | 1 | A floating-point register was written this cycle |
| csr_rdata | output | 32 | Status image: field in 14:13, summary in 31 |

## Verification
A software access to the status register and the dirty-marking pulse can both arrive in the same cycle. The bench provokes this by issuing a full write of 0x0 together with a `fpr_write` pulse, after first bringing the field to Initial. The result is judged correct only if the next read is 0x80006000, which shows the pulse took priority over the write. A similar clash with `fp_present` low shows that both sources are dropped.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;
  localparam int XLEN     = 32;
  localparam int FS_LSB   = 13;
  localparam int FS_W     = 2;
  localparam int FS_MSB   = FS_LSB + FS_W - 1;
  localparam int SUM_BIT  = XLEN - 1;

  typedef enum logic [FS_W-1:0] {
    FS_OFF   = 2'b00,
    FS_INIT  = 2'b01,
    FS_CLEAN = 2'b10,
    FS_DIRTY = 2'b11
  } fs_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;
endpackage

// File: rtl/fpctx_update.sv
module fpctx_update
  import fpctx_pkg::*;
(
  input  logic [FS_W-1:0] fs_q,
  input  logic [1:0]      op,
  input  logic [FS_W-1:0] wfield,
  output logic [FS_W-1:0] csr_fs
);
  always_comb begin
    unique case (csr_op_e'(op))
      OP_WRITE: csr_fs = wfield;
      OP_SET:   csr_fs = fs_q | wfield;
      OP_CLEAR: csr_fs = fs_q & ~wfield;
      default:  csr_fs = fs_q;
    endcase
  end
endmodule

// File: rtl/fpctx_next.sv
module fpctx_next
  import fpctx_pkg::*;
(
  input  logic            present,
  input  logic            mark,
  input  logic            hit,
  input  logic [FS_W-1:0] csr_fs,
  output logic [FS_W-1:0] fs_d,
  output logic            fs_en
);
  always_comb begin
    fs_en = 1'b1;
    if (!present)   fs_d = FS_OFF;
    else if (mark)  fs_d = FS_DIRTY;
    else if (hit)   fs_d = csr_fs;
    else begin
      fs_d  = FS_OFF;
      fs_en = 1'b0;
    end
  end
endmodule

// File: rtl/fpctx_image.sv
module fpctx_image
  import fpctx_pkg::*;
(
  input  logic [FS_W-1:0] fs_q,
  output logic [XLEN-1:0] image
);
  always_comb begin
    image                 = '0;
    image[FS_MSB:FS_LSB]  = fs_q;
    image[SUM_BIT]        = &fs_q;
  end
endmodule

// File: rtl/fpctx_status.sv
module fpctx_status
  import fpctx_pkg::*;
#(
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_present,
  input  logic              csr_valid,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        csr_op,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic              fpr_write,
  output logic [XLEN-1:0]   csr_rdata
);
  logic [FS_W-1:0] fs_q, fs_d, csr_fs;
  logic            fs_en, hit;
  logic            unused_wdata_bits;

  assign unused_wdata_bits = ^{csr_wdata[XLEN-1:FS_MSB+1], csr_wdata[FS_LSB-1:0]};
  assign hit = csr_valid && (csr_addr == STATUS_ADDR) && (csr_op != OP_NONE);

  fpctx_update u_update (
    .fs_q   (fs_q),
    .op     (csr_op),
    .wfield (csr_wdata[FS_MSB:FS_LSB]),
    .csr_fs (csr_fs)
  );

  fpctx_next u_next (
    .present (fp_present),
    .mark    (fpr_write),
    .hit     (hit),
    .csr_fs  (csr_fs),
    .fs_d    (fs_d),
    .fs_en   (fs_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fs_q <= FS_OFF;
    else if (fs_en) fs_q <= fs_d;
  end

  fpctx_image u_image (
    .fs_q  (fs_q),
    .image (csr_rdata)
  );
endmodule

// File: rtl/fpctx_status_chk.sv
module fpctx_status_chk
  import fpctx_pkg::*;
#(
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fp_present,
  input logic              csr_valid,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [1:0]        csr_op,
  input logic [FS_W-1:0]   wfield,
  input logic              fpr_write,
  input logic [XLEN-1:0]   csr_rdata
);
  logic hit, quiet;
  assign hit   = csr_valid && (csr_addr == STATUS_ADDR) && (csr_op != OP_NONE);
  assign quiet = fp_present && !fpr_write && !hit;

  p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_present && !fpr_write && hit && csr_op == OP_SET)
    |=> ((csr_rdata[FS_MSB:FS_LSB] & $past(wfield)) == $past(wfield)));

  p_clear_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_present && !fpr_write && hit && csr_op == OP_CLEAR)
    |=> ((csr_rdata[FS_MSB:FS_LSB] & $past(wfield)) == '0));

  p_dirty_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_present && fpr_write) |=> (csr_rdata[FS_MSB:FS_LSB] == FS_DIRTY));

  p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[SUM_BIT] == (csr_rdata[FS_MSB:FS_LSB] == FS_DIRTY));

  p_mark_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_present && fpr_write && hit) |=> csr_rdata[SUM_BIT]);

  p_absent_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_present |=> (csr_rdata == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(csr_rdata));

  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata & ~(32'h8000_0000 | (32'h3 << FS_LSB))) == '0);
endmodule

bind fpctx_status fpctx_status_chk #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fp_present (fp_present),
  .csr_valid  (csr_valid),
  .csr_addr   (csr_addr),
  .csr_op     (csr_op),
  .wfield     (csr_wdata[14:13]),
  .fpr_write  (fpr_write),
  .csr_rdata  (csr_rdata)
);

// File: tb/fpctx_status_tb.sv
module fpctx_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] SADDR = 12'h300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fp_present;
  logic        csr_valid;
  logic [11:0] csr_addr;
  logic [1:0]  csr_op;
  logic [31:0] csr_wdata;
  logic        fpr_write;
  logic [31:0] csr_rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpctx_status u_dut (
    .clk(clk), .rst_n(rst_n), .fp_present(fp_present), .csr_valid(csr_valid),
    .csr_addr(csr_addr), .csr_op(csr_op), .csr_wdata(csr_wdata),
    .fpr_write(fpr_write), .csr_rdata(csr_rdata)
  );

  task automatic compare(input logic [31:0] exp, input string tag);
    checks++;
    if (csr_rdata !== exp) begin
      failures++;
      $display("FAIL %s: rdata=%08h expected=%08h", tag, csr_rdata, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the value expected after the edge.
  task automatic drive(input bit pres, input bit v, input logic [11:0] a,
                       input logic [1:0] op, input logic [31:0] wd, input bit fw,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    fp_present = pres; csr_valid = v; csr_addr = a; csr_op = op;
    csr_wdata = wd; fpr_write = fw;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  // Monitor: after each edge, pop and compare.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() != 0) compare(q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    rst_n = 1'b0; fp_present = 1'b1; csr_valid = 1'b0; csr_addr = SADDR;
    csr_op = 2'b00; csr_wdata = '0; fpr_write = 1'b0;
    #2 compare(32'h0, "R1 during reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1 compare(32'h0, "R1 after release");

    drive(1, 1, SADDR, 2'b01, 32'h0000_2000, 0, 32'h0000_2000, "R2 write initial");
    drive(1, 0, SADDR, 2'b00, 32'h0, 1, 32'h8000_6000, "R5 mark dirty");
    drive(1, 1, SADDR, 2'b01, 32'h0, 0, 32'h0, "R2 write off");
    drive(1, 1, SADDR, 2'b10, 32'h0000_4000, 0, 32'h0000_4000, "R3 set clean");
    drive(1, 1, SADDR, 2'b10, 32'h0000_2000, 0, 32'h8000_6000, "R3 set to dirty");
    drive(1, 1, SADDR, 2'b01, 32'h0000_2000, 0, 32'h0000_2000, "R2 rewrite initial");
    drive(1, 0, SADDR, 2'b00, 32'h0, 1, 32'h8000_6000, "R5 mark again");
    drive(1, 1, SADDR, 2'b10, 32'h0000_4000, 0, 32'h8000_6000, "R3 set on dirty");
    drive(1, 1, SADDR, 2'b11, 32'h8000_2000, 0, 32'h0000_4000, "R4 clear to clean");
    drive(1, 1, SADDR, 2'b01, 32'h8000_0000, 0, 32'h0, "R6 bit31 write ignored");
    drive(1, 1, SADDR, 2'b01, 32'hFFFF_9FFF, 0, 32'h0, "R10 spare bits");
    drive(1, 1, SADDR, 2'b01, 32'hFFFF_FFFF, 0, 32'h8000_6000, "R10 all ones");
    drive(1, 1, SADDR, 2'b11, 32'h8000_0000, 0, 32'h8000_6000, "R6 clear bit31 ignored");
    drive(1, 1, SADDR, 2'b01, 32'h0000_2000, 0, 32'h0000_2000, "R2 prep collide");
    drive(1, 1, SADDR, 2'b01, 32'h0, 1, 32'h8000_6000, "R7 write with mark");
    drive(1, 1, SADDR, 2'b11, 32'h0000_6000, 1, 32'h8000_6000, "R7 clear with mark");
    drive(1, 1, 12'h301, 2'b11, 32'h0000_6000, 0, 32'h8000_6000, "R9 foreign clear");
    drive(1, 1, SADDR, 2'b01, 32'h0000_4000, 0, 32'h0000_4000, "R2 write clean");
    drive(1, 1, 12'h001, 2'b01, 32'h0000_6000, 0, 32'h0000_4000, "R9 foreign write");
    drive(1, 1, SADDR, 2'b00, 32'h0000_6000, 0, 32'h0000_4000, "R11 op none");
    drive(1, 0, SADDR, 2'b01, 32'h0000_2000, 0, 32'h0000_4000, "R11 valid low");
    drive(0, 0, SADDR, 2'b00, 32'h0, 0, 32'h0, "R8 absent forces off");
    drive(0, 0, SADDR, 2'b00, 32'h0, 1, 32'h0, "R8 mark ignored");
    drive(0, 1, SADDR, 2'b01, 32'h0000_6000, 1, 32'h0, "R8 write and mark ignored");
    drive(1, 0, SADDR, 2'b00, 32'h0, 0, 32'h0, "R8 stays off on return");
    drive(1, 0, SADDR, 2'b00, 32'h0, 1, 32'h8000_6000, "R5 mark after return");
    drive(1, 0, SADDR, 2'b00, 32'h0, 0, 32'h8000_6000, "R11 idle hold");

    @(negedge clk);
    fpr_write = 1'b0; csr_valid = 1'b0; csr_op = 2'b00;
    while (q_exp.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: rdata=%08h expected=completion", csr_rdata);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule